// File: doc/BRIEF.md
# Privilege-Aware Interrupt Selector

This block decides, once per instruction boundary, whether a pending interrupt is taken and how it is described. It looks at the current privilege mode and at three status words. Each mode has its own global enable bit, in its own status word and at its own position. It also looks at three request lines: a local timer/software source, a serial-port source and a block-storage source.

When the enable for the current mode is set, the highest-priority pending source wins. The result is a cause class (software or external), the privilege level the interrupt targets, and, for device sources, the device's IRQ number. The result is registered and presented one clock later. The valid flag marks it. A trap-entry unit downstream consumes it.

Top module: `priv_irq_selector`

## Requirements
- R1: In machine mode (mode code 2'b11), an interrupt is taken only if bit 3 of the machine status input is 1. With that bit 0, the valid output is 0 whatever is pending.
- R2: In supervisor mode (code 2'b01), an interrupt is taken only if bit 1 of the supervisor status input is 1.
- R3: In user mode (code 2'b00), an interrupt is taken only if bit 0 of the user status input is 1.
- R4: The reserved mode code 2'b10 applies no enable gating. Any pending source is taken, and its level output is machine (2'b11).
- R5: The local timer/software request beats both device requests. It gives cause 0 (software) and IRQ number 0. In a defined mode, the level equals the current mode code.
- R6: If the local request is absent, the serial-port request beats the storage request. It gives cause 1 (external) with IRQ number SERIAL_IRQ (default 10).
- R7: A storage request alone gives cause 1 (external) with IRQ number STORAGE_IRQ (default 1).
- R8: When nothing is pending or the relevant enable is clear, the valid, cause, level and IRQ number outputs are all 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. While reset is high, and on the first cycle after it, all outputs are 0.
- R10: Status bits other than the one selected by the current mode have no effect. For example, in machine mode, setting the supervisor and user enable bits does not allow an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode_i | input | 2 | Current privilege mode code |
| mach_stat_i | input | STAT_W | Machine status word |
| sup_stat_i | input | STAT_W | Supervisor status word |
| usr_stat_i | input | STAT_W | User status word |
| req_local_i | input | 1 | Local timer/software request |
| req_serial_i | input | 1 | Serial-port request |
| req_storage_i | input | 1 | Block-storage request |
| irq_valid_o | output | 1 | Interrupt taken this cycle |
| irq_cause_o | output | 1 | 0 software, 1 external |
| irq_level_o | output | 2 | Target privilege level |
| irq_num_o | output | IRQ_W | Device IRQ number, 0 for software |

## Verification
The hardest case to reach is a status word whose bits are set everywhere except at the one position the current mode reads. Random status words almost never produce this pattern. The reserved mode code is hard to reach for the same reason: ordinary traffic never uses it. The stimulus therefore sweeps every mode code against every combination of the three request lines, with the selected enable bit forced both ways. Directed vectors then set only the bits of the other two modes. Random status words, mixed in with a fixed seed, cover the remaining space.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    typedef enum logic [1:0] {
        PRIV_USR  = 2'b00,
        PRIV_SUP  = 2'b01,
        PRIV_RSV  = 2'b10,
        PRIV_MACH = 2'b11
    } priv_e;

    typedef enum logic {
        CAUSE_SW  = 1'b0,
        CAUSE_EXT = 1'b1
    } cause_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_LOCAL,
        SRC_SERIAL,
        SRC_STORAGE
    } src_e;

    localparam int MACH_EN_POS = 3;
    localparam int SUP_EN_POS  = 1;
    localparam int USR_EN_POS  = 0;

    typedef struct packed {
        logic   valid;
        cause_e cause;
        priv_e  level;
    } irq_head_t;

    // The target level follows the mode; the reserved code falls back to machine.
    function automatic priv_e target_level(input priv_e mode);
        return (mode == PRIV_RSV) ? PRIV_MACH : mode;
    endfunction

endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
    import irqsel_pkg::*;
#(
    parameter int STAT_W = 64
) (
    input  priv_e             mode,
    input  logic [STAT_W-1:0] mach_stat,
    input  logic [STAT_W-1:0] sup_stat,
    input  logic [STAT_W-1:0] usr_stat,
    output logic              open
);
    logic stat_unused;
    assign stat_unused = ^{mach_stat, sup_stat, usr_stat};

    always_comb begin
        unique case (mode)
            PRIV_MACH: open = mach_stat[MACH_EN_POS];
            PRIV_SUP:  open = sup_stat[SUP_EN_POS];
            PRIV_USR:  open = usr_stat[USR_EN_POS];
            default:   open = 1'b1;
        endcase
    end
endmodule

// File: rtl/irqsel_arb.sv
module irqsel_arb
    import irqsel_pkg::*;
(
    input  logic open,
    input  logic req_local,
    input  logic req_serial,
    input  logic req_storage,
    output src_e winner
);
    always_comb begin
        winner = SRC_NONE;
        if (open) begin
            if (req_local)        winner = SRC_LOCAL;
            else if (req_serial)  winner = SRC_SERIAL;
            else if (req_storage) winner = SRC_STORAGE;
        end
    end
endmodule

// File: rtl/irqsel_form.sv
module irqsel_form
    import irqsel_pkg::*;
#(
    parameter int IRQ_W       = 5,
    parameter int SERIAL_IRQ  = 10,
    parameter int STORAGE_IRQ = 1
) (
    input  src_e             winner,
    input  priv_e            mode,
    output irq_head_t        head,
    output logic [IRQ_W-1:0] num
);
    localparam logic [IRQ_W-1:0] SER_NUM = IRQ_W'(SERIAL_IRQ);
    localparam logic [IRQ_W-1:0] STO_NUM = IRQ_W'(STORAGE_IRQ);

    always_comb begin
        head = '0;
        num  = '0;
        unique case (winner)
            SRC_LOCAL: begin
                head.valid = 1'b1;
                head.cause = CAUSE_SW;
                head.level = target_level(mode);
            end
            SRC_SERIAL: begin
                head.valid = 1'b1;
                head.cause = CAUSE_EXT;
                head.level = target_level(mode);
                num        = SER_NUM;
            end
            SRC_STORAGE: begin
                head.valid = 1'b1;
                head.cause = CAUSE_EXT;
                head.level = target_level(mode);
                num        = STO_NUM;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/priv_irq_selector.sv
module priv_irq_selector
    import irqsel_pkg::*;
#(
    parameter int STAT_W      = 64,
    parameter int IRQ_W       = 5,
    parameter int SERIAL_IRQ  = 10,
    parameter int STORAGE_IRQ = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        priv_mode_i,
    input  logic [STAT_W-1:0] mach_stat_i,
    input  logic [STAT_W-1:0] sup_stat_i,
    input  logic [STAT_W-1:0] usr_stat_i,
    input  logic              req_local_i,
    input  logic              req_serial_i,
    input  logic              req_storage_i,
    output logic              irq_valid_o,
    output logic              irq_cause_o,
    output logic [1:0]        irq_level_o,
    output logic [IRQ_W-1:0]  irq_num_o
);
    priv_e            mode;
    logic             open;
    src_e             winner;
    irq_head_t        head_d, head_q;
    logic [IRQ_W-1:0] num_d, num_q;

    assign mode = priv_e'(priv_mode_i);

    irqsel_gate #(.STAT_W(STAT_W)) u_gate (
        .mode      (mode),
        .mach_stat (mach_stat_i),
        .sup_stat  (sup_stat_i),
        .usr_stat  (usr_stat_i),
        .open      (open)
    );

    irqsel_arb u_arb (
        .open        (open),
        .req_local   (req_local_i),
        .req_serial  (req_serial_i),
        .req_storage (req_storage_i),
        .winner      (winner)
    );

    irqsel_form #(
        .IRQ_W       (IRQ_W),
        .SERIAL_IRQ  (SERIAL_IRQ),
        .STORAGE_IRQ (STORAGE_IRQ)
    ) u_form (
        .winner (winner),
        .mode   (mode),
        .head   (head_d),
        .num    (num_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            num_q  <= '0;
        end else begin
            head_q <= head_d;
            num_q  <= num_d;
        end
    end

    assign irq_valid_o = head_q.valid;
    assign irq_cause_o = head_q.cause;
    assign irq_level_o = head_q.level;
    assign irq_num_o   = num_q;
endmodule

// File: rtl/priv_irq_selector_chk.sv
module priv_irq_selector_chk #(
    parameter int STAT_W      = 64,
    parameter int IRQ_W       = 5,
    parameter int SERIAL_IRQ  = 10,
    parameter int STORAGE_IRQ = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        priv_mode_i,
    input logic [STAT_W-1:0] mach_stat_i,
    input logic [STAT_W-1:0] sup_stat_i,
    input logic [STAT_W-1:0] usr_stat_i,
    input logic              req_local_i,
    input logic              req_serial_i,
    input logic              req_storage_i,
    input logic              irq_valid_o,
    input logic              irq_cause_o,
    input logic [1:0]        irq_level_o,
    input logic [IRQ_W-1:0]  irq_num_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_mach_gate_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(priv_mode_i == 2'b11 && !mach_stat_i[3]) |-> !irq_valid_o);

    p_sup_gate_r2: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(priv_mode_i == 2'b01 && !sup_stat_i[1]) |-> !irq_valid_o);

    p_usr_gate_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(priv_mode_i == 2'b00 && !usr_stat_i[0]) |-> !irq_valid_o);

    p_rsv_mode_r4: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(priv_mode_i == 2'b10 && (req_local_i || req_serial_i || req_storage_i))
        |-> irq_valid_o && irq_level_o == 2'b11);

    p_local_first_r5: assert property (@(posedge clk) disable iff (rst)
        past_ok && irq_valid_o && $past(req_local_i) |-> !irq_cause_o && irq_num_o == '0);

    p_serial_wins_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok && irq_valid_o && $past(!req_local_i && req_serial_i)
        |-> irq_cause_o && irq_num_o == IRQ_W'(SERIAL_IRQ));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_valid_o |-> !irq_cause_o && irq_level_o == 2'b00 && irq_num_o == '0);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> !irq_valid_o);
endmodule

bind priv_irq_selector priv_irq_selector_chk #(
    .STAT_W(STAT_W), .IRQ_W(IRQ_W), .SERIAL_IRQ(SERIAL_IRQ), .STORAGE_IRQ(STORAGE_IRQ)
) u_chk (.*);

// File: tb/priv_irq_selector_bench.sv
module priv_irq_selector_bench;
    localparam int STAT_W = 64;
    localparam int IRQ_W  = 5;
    localparam int SER    = 10;
    localparam int STO    = 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode = 2'b00;
    logic [STAT_W-1:0] ms = '0, ss = '0, us = '0;
    logic              rl = 1'b0, rse = 1'b0, rst_req = 1'b0;
    logic              v, c;
    logic [1:0]        lvl;
    logic [IRQ_W-1:0]  num;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    priv_irq_selector #(.STAT_W(STAT_W), .IRQ_W(IRQ_W), .SERIAL_IRQ(SER), .STORAGE_IRQ(STO))
    u_priv_irq_selector (
        .clk(clk), .rst(rst), .priv_mode_i(mode),
        .mach_stat_i(ms), .sup_stat_i(ss), .usr_stat_i(us),
        .req_local_i(rl), .req_serial_i(rse), .req_storage_i(rst_req),
        .irq_valid_o(v), .irq_cause_o(c), .irq_level_o(lvl), .irq_num_o(num)
    );

    // Expected packed result {valid, cause, level, num}.
    function automatic logic [3+IRQ_W:0] model(input logic [1:0] m,
        input logic [STAT_W-1:0] a, input logic [STAT_W-1:0] b, input logic [STAT_W-1:0] u,
        input logic l, input logic s, input logic t);
        logic en;
        logic [1:0] tl;
        case (m)
            2'b11: en = a[3];
            2'b01: en = b[1];
            2'b00: en = u[0];
            default: en = 1'b1;
        endcase
        tl = (m == 2'b10) ? 2'b11 : m;
        if (!en) return '0;
        if (l) return {1'b1, 1'b0, tl, IRQ_W'(0)};
        if (s) return {1'b1, 1'b1, tl, IRQ_W'(SER)};
        if (t) return {1'b1, 1'b1, tl, IRQ_W'(STO)};
        return '0;
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic l, input logic s,
                                     input logic t, input logic exp_v);
        if (!exp_v) begin
            if (!(l || s || t)) return "R8";
            if (m == 2'b11) return "R1";
            if (m == 2'b01) return "R2";
            return "R3";
        end
        if (m == 2'b10) return "R4";
        if (l) return "R5";
        if (s) return "R6";
        return "R7";
    endfunction

    task automatic apply_and_check(input logic [1:0] m, input logic [STAT_W-1:0] a,
        input logic [STAT_W-1:0] b, input logic [STAT_W-1:0] u,
        input logic l, input logic s, input logic t, input string extra);
        logic [3+IRQ_W:0] exp;
        logic [3+IRQ_W:0] got;
        string tg;
        mode = m; ms = a; ss = b; us = u; rl = l; rse = s; rst_req = t;
        exp = model(m, a, b, u, l, s, t);
        @(negedge clk);
        got = {v, c, lvl, num};
        tg = (extra != "") ? extra : tag_of(m, l, s, t, exp[3+IRQ_W]);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s mode=%b req=%b%b%b actual=%h expected=%h",
                     tg, m, l, s, t, got, exp);
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: outputs zero during reset.
        checks++;
        if ({v, c, lvl, num} !== '0) begin
            fails++;
            $display("FAIL R9 reset actual=%h expected=0", {v, c, lvl, num});
        end
        // Request pending while reset is released: first cycle after still clear.
        rl = 1'b1; mode = 2'b10;
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (v !== 1'b0) begin
            fails++;
            $display("FAIL R9 first cycle actual=%b expected=0", v);
        end

        // Exhaustive sweep: every mode, selected enable both ways, all request mixes.
        for (int mi = 0; mi < 4; mi++) begin
            for (int e = 0; e < 2; e++) begin
                for (int r = 0; r < 8; r++) begin
                    logic [STAT_W-1:0] a, b, u;
                    a = '0; b = '0; u = '0;
                    a[3] = e[0]; b[1] = e[0]; u[0] = e[0];
                    apply_and_check(mi[1:0], a, b, u, r[2], r[1], r[0], "");
                end
            end
        end

        // R10: only the other modes' enable bits set, and all other bits set.
        apply_and_check(2'b11, '0, 64'h2, 64'h1, 1'b1, 1'b1, 1'b1, "R10");
        apply_and_check(2'b01, 64'h8, '0, 64'h1, 1'b1, 1'b0, 1'b1, "R10");
        apply_and_check(2'b00, 64'h8, 64'h2, '0, 1'b0, 1'b1, 1'b0, "R10");
        apply_and_check(2'b11, ~64'h8, ~64'h0, ~64'h0, 1'b0, 1'b0, 1'b1, "R10");
        apply_and_check(2'b01, ~64'h0, ~64'h2, ~64'h0, 1'b1, 1'b0, 1'b0, "R10");

        // R9: back-to-back changes track the previous edge.
        apply_and_check(2'b11, 64'h8, '0, '0, 1'b0, 1'b0, 1'b1, "R9");
        apply_and_check(2'b11, 64'h8, '0, '0, 1'b0, 1'b0, 1'b0, "R9");

        // Random stimulus.
        for (int k = 0; k < 400; k++) begin
            logic [2:0] rq;
            rq = 3'($urandom);
            apply_and_check(2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                            {$urandom, $urandom}, rq[2], rq[1], rq[0], "");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule